// File: doc/BRIEF.md
# Outbound Address Translation Region Matcher

This block keeps a small table of programmable outbound translation windows. Each window has a 64-bit start address, a 64-bit end address and a 64-bit target address. The translation unit of a host bridge uses it to redirect an outgoing request address to another address space. Software programs the windows through a narrow register write port. It first writes a viewport word that selects the direction and the window index. It then writes the base, limit, target, control and enable words of that window.

Every window works on a 64 KB granule. The start address uses the upper base word and the granule-aligned lower base word, with the 16 low bits forced to zero. The end address uses the 32-bit limit word, with its 16 low bits forced to one, and an upper word. That upper word comes from the upper base word unless the window's extended-limit flag is set. When the flag is set, it comes from a separate upper-limit word. A window whose end lies above the next 4 GB boundary past its start therefore only covers its full range when the flag is set.

Each request address is checked against all enabled windows, and the lowest-numbered matching window wins. On a hit the block returns `target + (address - start)` together with that window's transaction type and function number. On a miss it raises a miss flag and returns the address unchanged. The result is registered and appears one cycle after the request.

Top module: `obx_matcher`

## Requirements
- R1: While reset is applied and after it is released, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0, and every window is disabled, so a lookup made before any programming misses.
- R2: With the extended-limit flag clear, a window covers the addresses from {upper base, lower base[31:16], 16'h0000} to {upper base, limit[31:16], 16'hFFFF}, both ends included. The address one below the start misses, and so does the address one above the end.
- R3: With the extended-limit flag set, the upper 32 bits of the end address come from the upper-limit word. A window with base 0x0_F000_0000 and limit 0x1_0FFF_FFFF then hits 0x0_F000_0000, 0x1_0000_0000 and 0x1_0FFF_FFFF, and misses 0x1_1000_0000.
- R4: The same window with the flag clear ends at 0x0_0FFF_FFFF, which lies below its start, so it matches no address at all.
- R5: A hit returns {upper target, lower target[31:16], 16'h0000} + (address - start). The low 16 bits written to the lower base, lower limit and lower target words are ignored.
- R6: A hit returns the type and function number of the matching window on `rsp_type` and `rsp_func`.
- R7: When several enabled windows match, the one with the lowest index supplies the result.
- R8: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_addr` equals the request address, and `rsp_type` and `rsp_func` are 0. `rsp_hit` and `rsp_miss` are never 1 together.
- R9: A window whose enable bit is 0 never matches, so a lookup falls to the next matching window or misses.
- R10: While the viewport direction bit (bit 31) is 1 (inbound), writes to the window registers change no outbound window.
- R11: `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` = 1. When `rsp_valid` is 0, `rsp_hit` and `rsp_miss` are 0 and `rsp_addr` holds its last value.
- R12: Register offsets on `cfg_addr`:
  - 0 is the viewport: bit 31 is the direction (1 = inbound) and bits 7:0 are the window index.
  - 1 is control: type in bits 4:0, function in bits 10:8, extended-limit flag in bit 16.
  - 2 is enable: bit 31.
  - 3 and 4 are the lower and upper base.
  - 5 and 6 are the lower and upper limit.
  - 7 and 8 are the lower and upper target.

  A write is visible to a lookup made in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_addr | output | 64 | Translated address, or the request address on a miss |
| rsp_type | output | 5 | Transaction type of the matching window |
| rsp_func | output | 3 | Function number of the matching window |

## Verification
A lookup result is due on the first rising edge after the request is driven. The bench drives each request after a falling edge and samples the outputs 2 ns after the next rising edge, so every lookup check looks at exactly the registered result of that request. A register write is driven for one cycle and takes effect on its rising edge, so the bench issues a lookup in the very next cycle to show that the new value is already in use. Idle behaviour is sampled one edge after `req_valid` drops.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int ADDR_W    = 64;
  localparam int HALF_W    = 32;
  localparam int GRAN_BITS = 16;
  localparam int PAGE_W    = HALF_W - GRAN_BITS;
  localparam int TYPE_W    = 5;
  localparam int FUNC_W    = 3;
  localparam int CFG_AW    = 4;
  localparam int VIEW_IDX_W = 8;

  // field positions inside the written words
  localparam int CTRL_TYPE_LSB = 0;
  localparam int CTRL_FUNC_LSB = 8;
  localparam int CTRL_EXT_BIT  = 16;
  localparam int ENA_BIT       = 31;
  localparam int VIEW_DIR_BIT  = 31;

  typedef enum logic [CFG_AW-1:0] {
    REG_VIEW    = 4'd0,
    REG_CTRL    = 4'd1,
    REG_ENA     = 4'd2,
    REG_BASE_LO = 4'd3,
    REG_BASE_HI = 4'd4,
    REG_LIM_LO  = 4'd5,
    REG_LIM_HI  = 4'd6,
    REG_TGT_LO  = 4'd7,
    REG_TGT_HI  = 4'd8
  } cfg_reg_e;

  typedef struct packed {
    logic              en;
    logic              ext;
    logic [TYPE_W-1:0] typ;
    logic [FUNC_W-1:0] func;
    logic [PAGE_W-1:0] base_lo;
    logic [HALF_W-1:0] base_hi;
    logic [PAGE_W-1:0] lim_lo;
    logic [HALF_W-1:0] lim_hi;
    logic [PAGE_W-1:0] tgt_lo;
    logic [HALF_W-1:0] tgt_hi;
  } region_t;
endpackage

// File: rtl/obx_rst_sync.sv
module obx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/obx_cfg_regs.sv
module obx_cfg_regs
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [HALF_W-1:0]             cfg_wdata,
  output region_t [NUM_REGIONS-1:0]     regions,
  output logic                          view_inbound
);
  logic                  view_dir_q, view_dir_d;
  logic [VIEW_IDX_W-1:0] view_idx_q, view_idx_d;
  logic                  view_wr;

  assign view_wr = cfg_we && (cfg_addr == REG_VIEW);

  // viewport next state
  always_comb begin
    view_dir_d = view_dir_q;
    view_idx_d = view_idx_q;
    if (view_wr) begin
      view_dir_d = cfg_wdata[VIEW_DIR_BIT];
      view_idx_d = cfg_wdata[VIEW_IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_dir_q <= 1'b0;
      view_idx_q <= '0;
    end else if (view_wr) begin
      view_dir_q <= view_dir_d;
      view_idx_q <= view_idx_d;
    end
  end

  assign view_inbound = view_dir_q;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    region_t rgn_q, rgn_d;
    logic    rgn_wr;

    assign rgn_wr = cfg_we && !view_dir_q &&
                    (view_idx_q == VIEW_IDX_W'(r)) &&
                    (cfg_addr != REG_VIEW);

    always_comb begin
      rgn_d = rgn_q;
      case (cfg_reg_e'(cfg_addr))
        REG_CTRL: begin
          rgn_d.typ  = cfg_wdata[CTRL_TYPE_LSB +: TYPE_W];
          rgn_d.func = cfg_wdata[CTRL_FUNC_LSB +: FUNC_W];
          rgn_d.ext  = cfg_wdata[CTRL_EXT_BIT];
        end
        REG_ENA:     rgn_d.en      = cfg_wdata[ENA_BIT];
        REG_BASE_LO: rgn_d.base_lo = cfg_wdata[HALF_W-1:GRAN_BITS];
        REG_BASE_HI: rgn_d.base_hi = cfg_wdata;
        REG_LIM_LO:  rgn_d.lim_lo  = cfg_wdata[HALF_W-1:GRAN_BITS];
        REG_LIM_HI:  rgn_d.lim_hi  = cfg_wdata;
        REG_TGT_LO:  rgn_d.tgt_lo  = cfg_wdata[HALF_W-1:GRAN_BITS];
        REG_TGT_HI:  rgn_d.tgt_hi  = cfg_wdata;
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rgn_q <= '0;
      end else if (rgn_wr) begin
        rgn_q <= rgn_d;
      end
    end

    assign regions[r] = rgn_q;
  end
endmodule

// File: rtl/obx_region_cmp.sv
module obx_region_cmp
  import obx_pkg::*;
(
  input  logic              en,
  input  logic              ext,
  input  logic [PAGE_W-1:0] base_lo,
  input  logic [HALF_W-1:0] base_hi,
  input  logic [PAGE_W-1:0] lim_lo,
  input  logic [HALF_W-1:0] lim_hi,
  input  logic [PAGE_W-1:0] tgt_lo,
  input  logic [HALF_W-1:0] tgt_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat
);
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W-1:0] tgt_addr;
  logic [HALF_W-1:0] end_hi;

  always_comb begin
    // upper end word: base word unless the extended-limit flag is set
    end_hi     = ext ? lim_hi : base_hi;
    start_addr = {base_hi, base_lo, {GRAN_BITS{1'b0}}};
    end_addr   = {end_hi, lim_lo, {GRAN_BITS{1'b1}}};
    tgt_addr   = {tgt_hi, tgt_lo, {GRAN_BITS{1'b0}}};
    hit        = en && (addr >= start_addr) && (addr <= end_addr);
    xlat       = tgt_addr + (addr - start_addr);
  end
endmodule

// File: rtl/obx_prio_sel.sv
module obx_prio_sel
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic [NUM_REGIONS-1:0]             hit_vec,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_vec,
  input  logic [NUM_REGIONS-1:0][TYPE_W-1:0] typ_vec,
  input  logic [NUM_REGIONS-1:0][FUNC_W-1:0] func_vec,
  output logic                               any_hit,
  output logic [ADDR_W-1:0]                  sel_xlat,
  output logic [TYPE_W-1:0]                  sel_typ,
  output logic [FUNC_W-1:0]                  sel_func
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [IDX_W-1:0] sel_idx;

  // lowest index wins: scan downwards so the last assignment is the lowest
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |hit_vec;
  assign sel_xlat = xlat_vec[sel_idx];
  assign sel_typ  = typ_vec[sel_idx];
  assign sel_func = func_vec[sel_idx];
endmodule

// File: rtl/obx_matcher.sv
module obx_matcher
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [63:0]       rsp_addr,
  output logic [4:0]        rsp_type,
  output logic [2:0]        rsp_func
);
  logic                              rst_n_sync;
  region_t [NUM_REGIONS-1:0]         regions;
  logic                              view_inbound;
  logic [NUM_REGIONS-1:0]            region_en;
  logic [NUM_REGIONS-1:0]            hit_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_vec;
  logic [NUM_REGIONS-1:0][TYPE_W-1:0] typ_vec;
  logic [NUM_REGIONS-1:0][FUNC_W-1:0] func_vec;
  logic                              any_hit;
  logic [ADDR_W-1:0]                 sel_xlat;
  logic [TYPE_W-1:0]                 sel_typ;
  logic [FUNC_W-1:0]                 sel_func;

  obx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  obx_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .regions      (regions),
    .view_inbound (view_inbound)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign region_en[r] = regions[r].en;
    assign typ_vec[r]   = regions[r].typ;
    assign func_vec[r]  = regions[r].func;

    obx_region_cmp u_cmp (
      .en      (regions[r].en),
      .ext     (regions[r].ext),
      .base_lo (regions[r].base_lo),
      .base_hi (regions[r].base_hi),
      .lim_lo  (regions[r].lim_lo),
      .lim_hi  (regions[r].lim_hi),
      .tgt_lo  (regions[r].tgt_lo),
      .tgt_hi  (regions[r].tgt_hi),
      .addr    (req_addr),
      .hit     (hit_vec[r]),
      .xlat    (xlat_vec[r])
    );
  end

  obx_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
    .hit_vec  (hit_vec),
    .xlat_vec (xlat_vec),
    .typ_vec  (typ_vec),
    .func_vec (func_vec),
    .any_hit  (any_hit),
    .sel_xlat (sel_xlat),
    .sel_typ  (sel_typ),
    .sel_func (sel_func)
  );

  // result register: next state
  logic              valid_q, valid_d;
  logic              hit_q, hit_d;
  logic              miss_q, miss_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [TYPE_W-1:0] typ_q, typ_d;
  logic [FUNC_W-1:0] func_q, func_d;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && any_hit;
    miss_d  = req_valid && !any_hit;
    addr_d  = any_hit ? sel_xlat : req_addr;
    typ_d   = any_hit ? sel_typ  : '0;
    func_d  = any_hit ? sel_func : '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      addr_q <= '0;
      typ_q  <= '0;
      func_q <= '0;
    end else if (req_valid) begin
      addr_q <= addr_d;
      typ_q  <= typ_d;
      func_q <= func_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hit   = hit_q;
  assign rsp_miss  = miss_q;
  assign rsp_addr  = addr_q;
  assign rsp_type  = typ_q;
  assign rsp_func  = func_q;
endmodule

// File: rtl/obx_matcher_chk.sv
module obx_matcher_chk #(
  parameter int NUM_REGIONS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [63:0]            req_addr,
  input logic                   cfg_we,
  input logic [3:0]             cfg_addr,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_miss,
  input logic [63:0]            rsp_addr,
  input logic [4:0]             rsp_type,
  input logic [2:0]             rsp_func,
  input logic [NUM_REGIONS-1:0] en_vec,
  input logic                   view_inbound
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss)); // R8

  AST_MISS_ZERO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_type == 5'd0 && rsp_func == 3'd0)); // R8

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_miss |-> rsp_addr == $past(req_addr))); // R8

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr))); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R11

  AST_ALL_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && en_vec == '0) |=> rsp_miss); // R9

  AST_INBOUND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && view_inbound && cfg_addr != 4'd0) |=> $stable(en_vec)); // R10
endmodule

bind obx_matcher obx_matcher_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_addr     (rsp_addr),
  .rsp_type     (rsp_type),
  .rsp_func     (rsp_func),
  .en_vec       (region_en),
  .view_inbound (view_inbound)
);

// File: tb/obx_matcher_tb.sv
`timescale 1ns/1ps
module obx_matcher_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [63:0] rsp_addr;
  logic [4:0]  rsp_type;
  logic [2:0]  rsp_func;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  obx_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_func(rsp_func)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [63:0] addr;
    logic        hit;
    logic [63:0] xa;
    logic [4:0]  typ;
    logic [2:0]  func;
    logic [7:0]  req;
  } vec_t;

  // windows: 0 = [0x0_2000_0000..0x0_2000_FFFF]->0x8_0000_0000 t2 f1
  //          1 = [0x0_F000_0000..0x1_0FFF_FFFF] ext ->0x4000_0000 t4 f3
  //          2 = [0x0_2000_0000..0x0_2FFF_FFFF]->0x9_0000_0000 t1 f5
  //          3 = [0x3_0000_0000..0x3_0000_FFFF] disabled ->0xA_0000_0000 t7 f2
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0_2000_0000, 1'b1, 64'h8_0000_0000, 5'd2, 3'd1, 8'd5}, // R5 start, low base bits ignored
    '{64'h0_2000_FFFF, 1'b1, 64'h8_0000_FFFF, 5'd2, 3'd1, 8'd2}, // R2 end, granule ones
    '{64'h0_2000_8000, 1'b1, 64'h8_0000_8000, 5'd2, 3'd1, 8'd7}, // R7 overlap, lowest wins
    '{64'h0_2001_0000, 1'b1, 64'h9_0001_0000, 5'd1, 3'd5, 8'd6}, // R6 second window attrs
    '{64'h0_1FFF_FFFF, 1'b0, 64'h0_1FFF_FFFF, 5'd0, 3'd0, 8'd8}, // R8 start-1 passes through
    '{64'h0_3000_0000, 1'b0, 64'h0_3000_0000, 5'd0, 3'd0, 8'd2}, // R2 end+1 misses
    '{64'h0_F000_0000, 1'b1, 64'h0_4000_0000, 5'd4, 3'd3, 8'd3}, // R3 start
    '{64'h1_0000_0000, 1'b1, 64'h0_5000_0000, 5'd4, 3'd3, 8'd3}, // R3 across 4 GB
    '{64'h1_0FFF_FFFF, 1'b1, 64'h0_5FFF_FFFF, 5'd4, 3'd3, 8'd3}, // R3 end
    '{64'h1_1000_0000, 1'b0, 64'h1_1000_0000, 5'd0, 3'd0, 8'd3}, // R3 end+1
    '{64'h3_0000_0100, 1'b0, 64'h3_0000_0100, 5'd0, 3'd0, 8'd9}  // R9 disabled window
  };

  task automatic check(input string tag, input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // called at a falling edge; returns at the following falling edge
  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_window(input int idx, input logic [63:0] base,
                                input logic [63:0] lim, input bit ext,
                                input logic [63:0] tgt, input logic [4:0] typ,
                                input logic [2:0] func, input bit en);
    cfg_write(4'd0, 32'(idx));
    cfg_write(4'd1, {15'd0, ext, 5'd0, func, 3'd0, typ});
    cfg_write(4'd3, base[31:0]);
    cfg_write(4'd4, base[63:32]);
    cfg_write(4'd5, lim[31:0]);
    cfg_write(4'd6, lim[63:32]);
    cfg_write(4'd7, tgt[31:0]);
    cfg_write(4'd8, tgt[63:32]);
    cfg_write(4'd2, {en, 31'd0});
  endtask

  task automatic lookup(input string tag, input logic [63:0] a, input bit eh,
                        input logic [63:0] ea, input logic [4:0] et,
                        input logic [2:0] ef);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    #2;
    check(tag, rsp_valid === 1'b1 && rsp_hit === eh && rsp_miss === !eh &&
               rsp_addr === ea && rsp_type === et && rsp_func === ef,
          $sformatf("addr=%h: got v=%0b hit=%0b miss=%0b out=%h t=%0d f=%0d, expected v=1 hit=%0b miss=%0b out=%h t=%0d f=%0d",
                    a, rsp_valid, rsp_hit, rsp_miss, rsp_addr, rsp_type, rsp_func,
                    eh, !eh, ea, et, ef));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R11 watchdog expired: got no finish, expected finish");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    check("R1", rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0,
          $sformatf("in reset got v=%0b h=%0b m=%0b, expected 0 0 0", rsp_valid, rsp_hit, rsp_miss));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0,
          $sformatf("after reset got v=%0b h=%0b m=%0b, expected 0 0 0", rsp_valid, rsp_hit, rsp_miss));
    lookup("R1", 64'h0_2000_0000, 1'b0, 64'h0_2000_0000, 5'd0, 3'd0);

    // R12: register layout used for programming
    program_window(0, 64'h0_2000_1234, 64'h0_2000_0000, 1'b0, 64'h8_0000_ABCD, 5'd2, 3'd1, 1'b1);
    program_window(1, 64'h0_F000_0000, 64'h1_0FFF_FFFF, 1'b1, 64'h0_4000_0000, 5'd4, 3'd3, 1'b1);
    program_window(2, 64'h0_2000_0000, 64'h0_2FFF_FFFF, 1'b0, 64'h9_0000_0000, 5'd1, 3'd5, 1'b1);
    program_window(3, 64'h3_0000_0000, 64'h3_0000_FFFF, 1'b0, 64'hA_0000_0000, 5'd7, 3'd2, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      lookup($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].hit,
             VECS[i].xa, VECS[i].typ, VECS[i].func);
    end

    // R11: idle cycle after a lookup
    @(posedge clk);
    #2;
    check("R11", rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0 &&
                 rsp_addr === 64'h3_0000_0100,
          $sformatf("idle got v=%0b h=%0b m=%0b out=%h, expected 0 0 0 out=%h",
                    rsp_valid, rsp_hit, rsp_miss, rsp_addr, 64'h3_0000_0100));
    @(negedge clk);

    // R4: window 1 without the extended-limit flag covers nothing
    cfg_write(4'd0, 32'd1);
    cfg_write(4'd1, 32'h0000_0304);
    lookup("R4", 64'h0_F000_0000, 1'b0, 64'h0_F000_0000, 5'd0, 3'd0);
    lookup("R4", 64'h1_0000_0000, 1'b0, 64'h1_0000_0000, 5'd0, 3'd0);

    // R9: disable window 0, overlap falls to window 2
    cfg_write(4'd0, 32'd0);
    cfg_write(4'd2, 32'h0000_0000);
    lookup("R9", 64'h0_2000_8000, 1'b1, 64'h9_0000_8000, 5'd1, 3'd5);

    // R10: inbound viewport writes leave outbound window 3 disabled
    cfg_write(4'd0, 32'h8000_0003);
    cfg_write(4'd2, 32'h8000_0000);
    lookup("R10", 64'h3_0000_0100, 1'b0, 64'h3_0000_0100, 5'd0, 3'd0);

    // R12: enable takes effect for a lookup in the next cycle
    cfg_write(4'd0, 32'h0000_0003);
    cfg_write(4'd2, 32'h8000_0000);
    lookup("R12", 64'h3_0000_0100, 1'b1, 64'hA_0000_0100, 5'd7, 3'd2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule